// File: doc/BRIEF.md
# Linked DMA Channel Sequencer

This block is one DMA channel that walks a transfer described by a parameter entry. A small local store holds the entries. Entry 0 is the live descriptor, and it is also kept in registers. Each sync event makes the channel read one word from a source address and write it to a destination address. The channel then steps both addresses by signed byte offsets and counts down elements and frames.

When a frame boundary is crossed, the element count is refilled from a separate reload field. This lets the first frame of a transfer have a different length from the frames that follow. When the last element of the last frame completes, the channel pulses a completion output. It then either goes idle or pulls a chained entry out of the store. The chained entry is chosen by a byte offset and replaces the live descriptor, so a sequence of transfers runs with no further configuration traffic.

Software writes descriptor words through a simple write-only port. Memory traffic leaves on a single-beat request/acknowledge bus.

Top module: `dma_link_chan`

## Requirements
- R1: During and after reset, `bus_req`, `done` and `link_err` are low and the channel is disarmed.
- R2: Word w of entry e is written at `cfg_addr` = 6*e + w. The words are: w=0 options (bit0 frame-sync, bit1 chain enable, bit2 source steps, bit3 destination steps); w=1 source; w=2 counts (frames-minus-one in [31:16], elements per frame in [15:0]); w=3 destination; w=4 offsets (signed byte frame offset in [31:16], signed byte element offset in [15:0]); w=5 chain word (chain byte offset in [31:16], element reload in [15:0]). Writing w=0 of entry 0 arms the channel. Events that arrive while the channel is disarmed cause no bus activity.
- R3: With frame-sync = 0, each event performs exactly one move. The move is a read at the source address, followed by a write of the returned data to the destination address. Each request holds its address and direction stable until `bus_ack`.
- R4: After a move that does not end a frame, each address whose step bit is set advances by the sign-extended element offset. An address whose step bit is clear stays where it is.
- R5: After the last element of a frame, when frames remain, the stepping addresses advance by the sign-extended frame offset and the frame count drops by one. With frame-sync = 0, the element count is refilled from the reload field.
- R6: When the last element of the frame with frame count 0 has been written, `done` is high for exactly the one cycle after that write's `bus_ack`. If chaining is disabled, the channel is then disarmed.
- R7: With frame-sync = 1, one event moves a whole frame, with the moves back to back. The reload field is ignored, so every frame has the length given in the counts word.
- R8: With chaining enabled and a chain offset that is a multiple of 24 and below 24*N_ENTRIES, the entry at offset/24 is copied into the live descriptor over six cycles. The channel then stays armed, with no bus activity, until an event arrives.
- R9: A chain offset that is not a multiple of 24, or that points past the last entry, raises `link_err` together with `done`. Nothing is loaded, and the channel is disarmed.
- R10: Events that arrive while a move or a chain load is in progress are held in one pending flag, and several such events count as one. A pending event survives a chain load and starts the chained entry. It is dropped when the channel disarms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Descriptor word write strobe |
| cfg_addr | input | CFG_AW | Word index into the descriptor store |
| cfg_wdata | input | 32 | Descriptor word data |
| evt | input | 1 | Sync event |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Byte address of the current beat |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Beat accepted; read data valid with it |
| bus_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle transfer completion pulse |
| link_err | output | 1 | Chain offset rejected, pulsed with `done` |

## Verification
The hardest case to reach is an event that arrives during the final move of a chained transfer. That event has to survive both the completion and the six-cycle copy, and then start the next entry without any new event. The stimulus stretches the bus acknowledge latency so the channel stays inside its final read, raises the event at that point, and then expects the chained entry's move in the scoreboard with no further event from the bench. The same stretched window is used to fire two events in one move, and the scoreboard then expects only one extra move.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int unsigned WORDS_PER_ENTRY = 6;
  localparam int unsigned ENTRY_BYTES     = 24;
  localparam int unsigned ADDR_W          = 32;
  localparam int unsigned DATA_W          = 32;
  localparam int unsigned CNT_W           = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_RD, ST_WR, ST_LINK
  } chan_state_e;

  typedef struct packed {
    logic              fs;
    logic              link_en;
    logic              src_step;
    logic              dst_step;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [CNT_W-1:0]  fcnt;
    logic [CNT_W-1:0]  ecnt;
    logic [CNT_W-1:0]  fidx;
    logic [CNT_W-1:0]  eidx;
    logic [CNT_W-1:0]  link;
    logic [CNT_W-1:0]  erld;
  } act_t;

  // Merge one descriptor word into the live descriptor.
  function automatic act_t apply_word(act_t a, logic [2:0] sel, logic [DATA_W-1:0] d);
    act_t r;
    r = a;
    case (sel)
      3'd0: begin
        r.fs       = d[0];
        r.link_en  = d[1];
        r.src_step = d[2];
        r.dst_step = d[3];
      end
      3'd1: r.src = d;
      3'd2: begin r.fcnt = d[31:16]; r.ecnt = d[15:0]; end
      3'd3: r.dst = d;
      3'd4: begin r.fidx = d[31:16]; r.eidx = d[15:0]; end
      3'd5: begin r.link = d[31:16]; r.erld = d[15:0]; end
      default: ;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/dma_param_mem.sv
module dma_param_mem
  import dma_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 85,
  parameter int unsigned AW        = $clog2(N_ENTRIES * WORDS_PER_ENTRY)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = N_ENTRIES * WORDS_PER_ENTRY;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              wr_ok;
  logic              rd_ok;

  assign wr_ok = we && (32'(waddr) < 32'(DEPTH));
  assign rd_ok = 32'(raddr) < 32'(DEPTH);

  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[waddr] <= wdata;
  end

  assign rdata = rd_ok ? mem_q[raddr] : '0;
endmodule

// File: rtl/dma_link_decode.sv
module dma_link_decode
  import dma_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 85,
  parameter int unsigned AW        = $clog2(N_ENTRIES * WORDS_PER_ENTRY)
) (
  input  logic [CNT_W-1:0] link_off,
  output logic             link_ok,
  output logic [AW-1:0]    link_base
);
  logic [CNT_W-1:0] entry;
  logic [CNT_W-1:0] rem;

  assign entry     = link_off / CNT_W'(ENTRY_BYTES);
  assign rem       = link_off - entry * CNT_W'(ENTRY_BYTES);
  assign link_ok   = (rem == '0) && (32'(entry) < 32'(N_ENTRIES));
  assign link_base = AW'(32'(entry) * 32'(WORDS_PER_ENTRY));
endmodule

// File: rtl/dma_addr_adv.sv
module dma_addr_adv
  import dma_pkg::*;
(
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              step_en,
  input  logic              frame_end,
  input  logic [CNT_W-1:0]  eidx,
  input  logic [CNT_W-1:0]  fidx,
  output logic [ADDR_W-1:0] nxt_addr
);
  logic [CNT_W-1:0]  off;
  logic [ADDR_W-1:0] off_x;

  assign off      = frame_end ? fidx : eidx;
  assign off_x    = {{(ADDR_W-CNT_W){off[CNT_W-1]}}, off};
  assign nxt_addr = step_en ? cur_addr + off_x : cur_addr;
endmodule

// File: rtl/dma_link_chan.sv
module dma_link_chan
  import dma_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 85,
  parameter int unsigned CFG_AW    = $clog2(N_ENTRIES * WORDS_PER_ENTRY)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              evt,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              done,
  output logic              link_err
);
  localparam int unsigned N_ADDR  = 2;
  localparam logic [2:0]  LK_LAST = 3'(WORDS_PER_ENTRY - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q, arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign arst_n = rst_sync_q;

  chan_state_e       st_q, st_d;
  act_t              act_q, act_d;
  logic              pend_q, pend_d;
  logic [CNT_W-1:0]  burst_q, burst_d;
  logic [2:0]        lk_q, lk_d;
  logic [CFG_AW-1:0] lbase_q, lbase_d;
  logic [DATA_W-1:0] rdat_q;
  logic              rdat_en;
  logic              done_q, done_d, err_q, err_d;

  // descriptor store
  logic [DATA_W-1:0] mem_rdata;
  logic [CFG_AW-1:0] mem_raddr;
  assign mem_raddr = lbase_q + CFG_AW'(lk_q);

  dma_param_mem #(.N_ENTRIES(N_ENTRIES), .AW(CFG_AW)) u_mem (
    .clk   (clk),
    .we    (cfg_we),
    .waddr (cfg_addr),
    .wdata (cfg_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  // chain offset decode
  logic              link_ok;
  logic [CFG_AW-1:0] link_base;
  dma_link_decode #(.N_ENTRIES(N_ENTRIES), .AW(CFG_AW)) u_ldec (
    .link_off  (act_q.link),
    .link_ok   (link_ok),
    .link_base (link_base)
  );

  // position within frame and transfer
  logic last_elem, xfer_end;
  assign last_elem = act_q.fs ? (burst_q <= CNT_W'(1)) : (act_q.ecnt <= CNT_W'(1));
  assign xfer_end  = last_elem && (act_q.fcnt == '0);

  // address stepping, one adder per address
  logic [ADDR_W-1:0] cur_a   [N_ADDR];
  logic [ADDR_W-1:0] nxt_a   [N_ADDR];
  logic              step_en [N_ADDR];
  assign cur_a[0]   = act_q.src;
  assign cur_a[1]   = act_q.dst;
  assign step_en[0] = act_q.src_step;
  assign step_en[1] = act_q.dst_step;

  for (genvar k = 0; k < N_ADDR; k++) begin : g_adv
    dma_addr_adv u_adv (
      .cur_addr  (cur_a[k]),
      .step_en   (step_en[k]),
      .frame_end (last_elem),
      .eidx      (act_q.eidx),
      .fidx      (act_q.fidx),
      .nxt_addr  (nxt_a[k])
    );
  end

  // configuration hits on the live entry
  logic cfg_live, busy;
  assign cfg_live = cfg_we && (32'(cfg_addr) < 32'(WORDS_PER_ENTRY));
  assign busy     = (st_q == ST_RD) || (st_q == ST_WR) || (st_q == ST_LINK);
  assign rdat_en  = (st_q == ST_RD) && bus_ack;

  always_comb begin
    st_d    = st_q;
    act_d   = act_q;
    pend_d  = pend_q;
    burst_d = burst_q;
    lk_d    = lk_q;
    lbase_d = lbase_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    if (evt && busy) pend_d = 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        pend_d = 1'b0;
        if (cfg_live) begin
          act_d = apply_word(act_q, cfg_addr[2:0], cfg_wdata);
          if (cfg_addr[2:0] == 3'd0) st_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (cfg_live) act_d = apply_word(act_q, cfg_addr[2:0], cfg_wdata);
        if (evt || pend_q) begin
          st_d    = ST_RD;
          pend_d  = evt && pend_q;
          burst_d = act_q.ecnt;
        end
      end
      ST_RD: begin
        if (bus_ack) st_d = ST_WR;
      end
      ST_WR: begin
        if (bus_ack) begin
          if (xfer_end) begin
            done_d = 1'b1;
            if (act_q.link_en && link_ok) begin
              st_d    = ST_LINK;
              lk_d    = '0;
              lbase_d = link_base;
            end else begin
              st_d   = ST_IDLE;
              pend_d = 1'b0;
              err_d  = act_q.link_en;
            end
          end else begin
            act_d.src = nxt_a[0];
            act_d.dst = nxt_a[1];
            if (last_elem) begin
              act_d.fcnt = act_q.fcnt - CNT_W'(1);
              if (!act_q.fs) act_d.ecnt = act_q.erld;
              st_d = ST_WAIT;
            end else if (act_q.fs) begin
              burst_d = burst_q - CNT_W'(1);
              st_d    = ST_RD;
            end else begin
              act_d.ecnt = act_q.ecnt - CNT_W'(1);
              st_d       = ST_WAIT;
            end
          end
        end
      end
      ST_LINK: begin
        act_d = apply_word(act_q, lk_q, mem_rdata);
        lk_d  = lk_q + 3'd1;
        if (lk_q == LK_LAST) st_d = ST_WAIT;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q    <= ST_IDLE;
      act_q   <= '0;
      pend_q  <= 1'b0;
      burst_q <= '0;
      lk_q    <= '0;
      lbase_q <= '0;
      rdat_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      act_q   <= act_d;
      pend_q  <= pend_d;
      burst_q <= burst_d;
      lk_q    <= lk_d;
      lbase_q <= lbase_d;
      if (rdat_en) rdat_q <= bus_rdata;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign bus_req   = (st_q == ST_RD) || (st_q == ST_WR);
  assign bus_we    = (st_q == ST_WR);
  assign bus_addr  = (st_q == ST_WR) ? act_q.dst : act_q.src;
  assign bus_wdata = rdat_q;
  assign done      = done_q;
  assign link_err  = err_q;
endmodule

// File: rtl/dma_link_chan_chk.sv
module dma_link_chan_chk
  import dma_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              done,
  input logic              link_err
);
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  assert_read_then_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_ack) |=> (bus_req && bus_we));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_follows_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_req && bus_we && bus_ack));

  assert_quiet_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !bus_req);

  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_err |-> done);

  assert_err_disarms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_err |=> !bus_req);
endmodule

bind dma_link_chan dma_link_chan_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_ack  (bus_ack),
  .done     (done),
  .link_err (link_err)
);

// File: tb/dma_link_chan_bench.sv
module dma_link_chan_bench;
  localparam int N  = 85;
  localparam int AW = $clog2(N * 6);

  logic          clk, rst_n, cfg_we, evt;
  logic [AW-1:0] cfg_addr;
  logic [31:0]   cfg_wdata;
  logic          bus_req, bus_we, bus_ack, done, link_err;
  logic [31:0]   bus_addr, bus_wdata, bus_rdata;

  int checks = 0, errors = 0;
  int done_cnt = 0, err_cnt = 0, op_cnt = 0, ack_lat = 1;

  typedef struct packed { logic we; logic [31:0] addr; logic [31:0] data; } op_t;
  op_t   expq[$];
  string tagq[$];

  dma_link_chan #(.N_ENTRIES(N)) u_dma_link_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .evt(evt), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata), .done(done), .link_err(link_err)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  function automatic logic [31:0] rpat(logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16] ^ 16'h1E0F};
  endfunction

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // bus responder and scoreboard monitor
  initial begin
    int  wcnt;
    op_t e;
    string t;
    wcnt = 0;
    bus_ack = 1'b0;
    bus_rdata = '0;
    forever begin
      @(negedge clk);
      if (bus_ack) begin
        bus_ack = 1'b0;
        wcnt = 0;
      end else if (bus_req && rst_n) begin
        if (wcnt < ack_lat) wcnt++;
        else begin
          bus_ack = 1'b1;
          op_cnt++;
          if (!bus_we) bus_rdata = rpat(bus_addr);
          if (expq.size() == 0) begin
            chk(1'b0, $sformatf("R2 unexpected bus op actual we=%0d addr=%h expected none=%0d",
                                bus_we, bus_addr, 0));
          end else begin
            e = expq.pop_front();
            t = tagq.pop_front();
            chk((bus_we == e.we) && (bus_addr == e.addr) && (!e.we || bus_wdata == e.data),
                $sformatf("%s bus op actual we=%0d addr=%h data=%h expected we=%0d addr=%h data=%h",
                          t, bus_we, bus_addr, bus_wdata, e.we, e.addr, e.data));
          end
        end
      end
    end
  end

  // pulse counters
  initial begin
    forever begin
      @(negedge clk);
      if (done) done_cnt++;
      if (link_err) err_cnt++;
    end
  end

  task automatic cfg_write(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_addr = AW'(a);
    cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic write_entry(input int e, input logic [31:0] opt, src, cnt, dst, idx, rld);
    cfg_write(e * 6 + 1, src);
    cfg_write(e * 6 + 2, cnt);
    cfg_write(e * 6 + 3, dst);
    cfg_write(e * 6 + 4, idx);
    cfg_write(e * 6 + 5, rld);
    cfg_write(e * 6 + 0, opt);
  endtask

  task automatic pulse_evt();
    @(negedge clk);
    evt = 1'b1;
    @(negedge clk);
    evt = 1'b0;
  endtask

  task automatic expect_move(input logic [31:0] s, d, input string tag);
    expq.push_back('{we: 1'b0, addr: s, data: 32'h0});
    tagq.push_back(tag);
    expq.push_back('{we: 1'b1, addr: d, data: rpat(s)});
    tagq.push_back(tag);
  endtask

  task automatic wait_idle(input string tag);
    int n;
    n = 0;
    while (expq.size() != 0 && n < 600) begin
      @(negedge clk);
      n++;
    end
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, $sformatf("%s outstanding ops actual=%0d expected=0", tag, expq.size()));
    expq.delete();
    tagq.delete();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int ops0, d0;
    rst_n = 1'b0;
    cfg_we = 1'b0;
    cfg_addr = '0;
    cfg_wdata = '0;
    evt = 1'b0;
    repeat (3) @(negedge clk);
    chk(bus_req == 1'b0, $sformatf("R1 bus_req in reset actual=%0d expected=0", bus_req));
    chk(done == 1'b0, $sformatf("R1 done in reset actual=%0d expected=0", done));
    chk(link_err == 1'b0, $sformatf("R1 link_err in reset actual=%0d expected=0", link_err));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1/R2: disarmed after reset, event ignored
    pulse_evt();
    repeat (10) @(negedge clk);
    chk(op_cnt == 0, $sformatf("R1 R2 ops while disarmed actual=%0d expected=0", op_cnt));
    chk(done_cnt == 0, $sformatf("R1 done while disarmed actual=%0d expected=0", done_cnt));

    // R3 R4 R5 R6: fixed source, destination every other word, 3 then 2 elements
    write_entry(0, 32'h8, 32'h1000, {16'd1, 16'd3}, 32'h2000, {16'h0040, 16'h0008}, {16'd0, 16'd2});
    expect_move(32'h1000, 32'h2000, "R3");
    pulse_evt(); wait_idle("R3");
    expect_move(32'h1000, 32'h2008, "R4");
    pulse_evt(); wait_idle("R4");
    expect_move(32'h1000, 32'h2010, "R4");
    pulse_evt(); wait_idle("R4");
    expect_move(32'h1000, 32'h2050, "R5");
    pulse_evt(); wait_idle("R5");
    chk(done_cnt == 0, $sformatf("R5 done before reload frame ends actual=%0d expected=0", done_cnt));
    expect_move(32'h1000, 32'h2058, "R5");
    pulse_evt(); wait_idle("R5");
    chk(done_cnt == 1, $sformatf("R5 R6 done after reloaded frame actual=%0d expected=1", done_cnt));
    ops0 = op_cnt;
    pulse_evt();
    repeat (12) @(negedge clk);
    chk(op_cnt == ops0, $sformatf("R6 ops after unchained end actual=%0d expected=%0d", op_cnt, ops0));

    // R4 R8 R7: negative steps, chain to entry 2 which is frame-synced
    ack_lat = 0;
    write_entry(2, 32'hD, 32'h3000, {16'd1, 16'd2}, 32'h4000, {16'h0020, 16'h0004}, {16'd0, 16'd5});
    write_entry(0, 32'hE, 32'h1100, {16'd0, 16'd2}, 32'h2100, {16'h0000, 16'hFFFC}, {16'd48, 16'd0});
    expect_move(32'h1100, 32'h2100, "R4");
    pulse_evt(); wait_idle("R4");
    expect_move(32'h10FC, 32'h20FC, "R4");
    pulse_evt(); wait_idle("R4");
    ops0 = op_cnt;
    repeat (15) @(negedge clk);
    chk(op_cnt == ops0, $sformatf("R8 ops after chain load without event actual=%0d expected=%0d", op_cnt, ops0));
    chk(done_cnt == 2, $sformatf("R8 done count actual=%0d expected=2", done_cnt));
    chk(err_cnt == 0, $sformatf("R8 link_err on aligned chain actual=%0d expected=0", err_cnt));
    expect_move(32'h3000, 32'h4000, "R7");
    expect_move(32'h3004, 32'h4004, "R7");
    pulse_evt(); wait_idle("R7");
    chk(op_cnt == ops0 + 4, $sformatf("R7 ops for one event actual=%0d expected=%0d", op_cnt, ops0 + 4));
    chk(done_cnt == 2, $sformatf("R7 done after first frame actual=%0d expected=2", done_cnt));
    expect_move(32'h3024, 32'h4024, "R7");
    expect_move(32'h3028, 32'h4028, "R7");
    pulse_evt(); wait_idle("R7");
    chk(done_cnt == 3, $sformatf("R7 frame length ignores reload actual=%0d expected=3", done_cnt));

    // R10 R9: pending events, pending across chain load, misaligned chain
    ack_lat = 3;
    write_entry(3, 32'h2, 32'h5000, {16'd0, 16'd1}, 32'h6000, 32'h0, {16'd25, 16'd0});
    write_entry(0, 32'hA, 32'h1200, {16'd0, 16'd4}, 32'h2200, {16'h0000, 16'h0004}, {16'd72, 16'd0});
    ops0 = op_cnt;
    expect_move(32'h1200, 32'h2200, "R10");
    expect_move(32'h1200, 32'h2204, "R10");
    pulse_evt();
    while (!bus_req) @(negedge clk);
    pulse_evt();
    pulse_evt();
    wait_idle("R10");
    repeat (10) @(negedge clk);
    chk(op_cnt == ops0 + 4, $sformatf("R10 one-deep pending actual=%0d expected=%0d", op_cnt, ops0 + 4));
    expect_move(32'h1200, 32'h2208, "R10");
    pulse_evt(); wait_idle("R10");
    d0 = done_cnt;
    expect_move(32'h1200, 32'h220C, "R10");
    expect_move(32'h5000, 32'h6000, "R10");
    pulse_evt();
    while (!bus_req) @(negedge clk);
    pulse_evt();
    wait_idle("R10");
    repeat (10) @(negedge clk);
    chk(done_cnt == d0 + 2, $sformatf("R10 pending starts chained entry actual=%0d expected=%0d", done_cnt, d0 + 2));
    chk(err_cnt == 1, $sformatf("R9 misaligned chain flagged actual=%0d expected=1", err_cnt));
    ops0 = op_cnt;
    pulse_evt();
    repeat (15) @(negedge clk);
    chk(op_cnt == ops0, $sformatf("R9 ops after rejected chain actual=%0d expected=%0d", op_cnt, ops0));

    // R9: chain offset past the last entry
    ack_lat = 0;
    write_entry(0, 32'h2, 32'h1300, {16'd0, 16'd1}, 32'h2300, 32'h0, {16'd2040, 16'd0});
    d0 = done_cnt;
    expect_move(32'h1300, 32'h2300, "R9");
    pulse_evt(); wait_idle("R9");
    chk(err_cnt == 2, $sformatf("R9 out-of-range chain flagged actual=%0d expected=2", err_cnt));
    chk(done_cnt == d0 + 1, $sformatf("R9 done with error actual=%0d expected=%0d", done_cnt, d0 + 1));
    ops0 = op_cnt;
    pulse_evt();
    repeat (15) @(negedge clk);
    chk(op_cnt == ops0, $sformatf("R9 disarmed after range error actual=%0d expected=%0d", op_cnt, ops0));

    finish_run();
  end
endmodule